// File: doc/BRIEF.md
# Strobed Input Capture Unit

This block takes a parallel input word and hands it to the write port of an input FIFO. The capture moment comes from one of three sources: a one-clock pacer pulse from an on-chip timer, a selected edge of an external request strobe, or a full request/acknowledge exchange with the external device. Request, trigger and data arrive already noise-filtered but still asynchronous, so request and trigger pass through a synchronizer chain. The data word is delayed by the same number of stages so that it stays aligned with the request.

Sampling stays disabled until the trigger input shows a rising edge. After that the unit remains armed until reset. In handshake mode the word is written first and the acknowledge pulse follows. The acknowledge is held back while the FIFO reports full, which keeps the external device paced so that no word is lost. In strobe mode the device cannot be paced, so a strobe that meets a full FIFO drops its word and sets a sticky overrun flag.

Top module: `incap_top`

## Requirements
- R1: After reset, `fifo_wr`, `ack_out` and `overrun` are low. The unit is disarmed and the handshake sequencer is idle.
- R2: No word is written before a rising edge of `trig_in`. Once armed, the unit stays armed until reset, even after `trig_in` returns low.
- R3: With `cfg_mode` = 0 (pacer), each `pacer_tick` pulse that is seen while armed and while `fifo_full` is low causes exactly one write of the held `data_in` word. A tick that is seen while `fifo_full` is high writes nothing. `req_in` has no effect in this mode.
- R4: With `cfg_mode` = 1 (strobe), each active edge of `req_in` causes exactly one write of the `data_in` word that was present at the edge. `ack_out` stays low.
- R5: `cfg_fall_edge` = 0 makes only rising `req_in` edges active, and `cfg_fall_edge` = 1 makes only falling edges active. This holds in both strobe mode and handshake mode.
- R6: In strobe mode, an active edge that meets `fifo_full` high writes nothing and sets `overrun`. `overrun` stays high until reset.
- R7: With `cfg_mode` = 2 (handshake), an active request edge causes one write. `ack_out` rises exactly one clock after the cycle in which `fifo_wr` is high.
- R8: In handshake mode, while `fifo_full` is high, the write and the acknowledge are both withheld. The write takes place in the first clock in which `fifo_full` is low.
- R9: The acknowledge pulse lasts `cfg_ack_len` clocks. Values below 2 give 2 clocks.
- R10: With `cfg_mode` = 3 (off), neither ticks nor request edges write a word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_mode | input | 2 | Capture source: 0 pacer, 1 strobe, 2 handshake, 3 off |
| cfg_fall_edge | input | 1 | 1 selects the falling edge of `req_in` as active |
| cfg_ack_len | input | ACK_LEN_W | Acknowledge pulse length in clocks (minimum 2) |
| trig_in | input | 1 | Filtered trigger; its rising edge arms sampling |
| pacer_tick | input | 1 | One-clock pacer pulse from the internal timer |
| req_in | input | 1 | Filtered external request or strobe |
| data_in | input | DATA_W | Filtered parallel input word |
| fifo_full | input | 1 | Input FIFO has no free entry |
| fifo_wr | output | 1 | FIFO write enable, one clock per word |
| fifo_wdata | output | DATA_W | Word written with `fifo_wr` |
| ack_out | output | 1 | Acknowledge pulse to the external device |
| overrun | output | 1 | Sticky flag: a strobe found the FIFO full |

## Verification
Every capture source receives the same stimulus: a pacer tick together with a request edge in one direction. One run of stimulus therefore shows which event actually produces the write, and also that a driven request edge in the unselected direction writes nothing. Handshake runs use acknowledge lengths of 0, 1, 5 and 17. These values separate the clamp to two clocks from a plain count. They also show the one-clock spacing between the write and the acknowledge. Full-FIFO runs compare three cases: a pacer tick that is simply dropped, a strobe that is dropped and flagged, and a handshake that waits and completes as soon as space appears.

// File: rtl/incap_pkg.sv
package incap_pkg;

   typedef enum logic [1:0] {
      CAP_PACER  = 2'd0,
      CAP_STROBE = 2'd1,
      CAP_HSHAKE = 2'd2,
      CAP_OFF    = 2'd3
   } cap_mode_e;

   typedef enum logic [1:0] {
      HS_IDLE = 2'd0,
      HS_PEND = 2'd1,
      HS_ACK  = 2'd2
   } hs_state_e;

endpackage

// File: rtl/incap_sync_edge.sv
module incap_sync_edge #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic din,
   input  logic sel_fall,
   output logic hit
);
   logic [STAGES-1:0] sq;
   logic              prev;
   logic              now_lvl;

   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("incap_sync_edge: STAGES must be at least 2");
      end
   endgenerate

   assign now_lvl = sq[STAGES-1];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sq   <= '0;
         prev <= 1'b0;
      end else begin
         sq   <= {sq[STAGES-2:0], din};
         prev <= now_lvl;
      end
   end

   assign hit = sel_fall ? (prev & ~now_lvl) : (now_lvl & ~prev);

endmodule

// File: rtl/incap_ack_gen.sv
module incap_ack_gen #(
   parameter int LEN_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic [LEN_W-1:0] len,
   output logic             ack
);
   localparam logic [LEN_W-1:0] MIN_LEN = LEN_W'(2);
   localparam logic [LEN_W-1:0] ONE     = LEN_W'(1);

   logic [LEN_W-1:0] len_eff;
   logic [LEN_W-1:0] cnt;

   generate
      if (LEN_W < 2) begin : g_bad_len
         $error("incap_ack_gen: LEN_W must be at least 2");
      end
   endgenerate

   assign len_eff = (len < MIN_LEN) ? MIN_LEN : len;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ack <= 1'b0;
         cnt <= '0;
      end else if (start) begin
         ack <= 1'b1;
         cnt <= len_eff - ONE;
      end else if (ack) begin
         if (cnt == '0) ack <= 1'b0;
         else           cnt <= cnt - ONE;
      end
   end

endmodule

// File: rtl/incap_top.sv
module incap_top
   import incap_pkg::*;
#(
   parameter int DATA_W      = 32,
   parameter int SYNC_STAGES = 2,
   parameter int ACK_LEN_W   = 8,
   parameter bit DATA_ALIGN  = 1'b1
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [1:0]           cfg_mode,
   input  logic                 cfg_fall_edge,
   input  logic [ACK_LEN_W-1:0] cfg_ack_len,
   input  logic                 trig_in,
   input  logic                 pacer_tick,
   input  logic                 req_in,
   input  logic [DATA_W-1:0]    data_in,
   input  logic                 fifo_full,
   output logic                 fifo_wr,
   output logic [DATA_W-1:0]    fifo_wdata,
   output logic                 ack_out,
   output logic                 overrun
);
   cap_mode_e         mode;
   hs_state_e         hs_st;
   logic              req_hit;
   logic              trig_hit;
   logic              armed;
   logic              ack_start;
   logic [DATA_W-1:0] word_now;
   logic [DATA_W-1:0] hold;

   generate
      if (DATA_W < 1) begin : g_bad_width
         $error("incap_top: DATA_W must be positive");
      end
   endgenerate

   assign mode = cap_mode_e'(cfg_mode);

   incap_sync_edge #(.STAGES(SYNC_STAGES)) u_req_sync (
      .clk     (clk),
      .rst_n   (rst_n),
      .din     (req_in),
      .sel_fall(cfg_fall_edge),
      .hit     (req_hit)
   );

   incap_sync_edge #(.STAGES(SYNC_STAGES)) u_trig_sync (
      .clk     (clk),
      .rst_n   (rst_n),
      .din     (trig_in),
      .sel_fall(1'b0),
      .hit     (trig_hit)
   );

   // The data word either follows the request through the same number of
   // stages, or is taken straight from the pins.
   generate
      if (DATA_ALIGN) begin : g_align
         logic [DATA_W-1:0] dq [SYNC_STAGES];
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               for (int i = 0; i < SYNC_STAGES; i++) dq[i] <= '0;
            end else begin
               for (int i = SYNC_STAGES - 1; i > 0; i--) dq[i] <= dq[i-1];
               dq[0] <= data_in;
            end
         end
         assign word_now = dq[SYNC_STAGES-1];
      end else begin : g_direct
         assign word_now = data_in;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) armed <= 1'b0;
      else if (trig_hit) armed <= 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         fifo_wr    <= 1'b0;
         fifo_wdata <= '0;
         overrun    <= 1'b0;
         ack_start  <= 1'b0;
         hold       <= '0;
         hs_st      <= HS_IDLE;
      end else begin
         fifo_wr   <= 1'b0;
         ack_start <= 1'b0;

         case (mode)
            CAP_PACER: begin
               if (armed && pacer_tick && !fifo_full) begin
                  fifo_wr    <= 1'b1;
                  fifo_wdata <= word_now;
               end
            end
            CAP_STROBE: begin
               if (armed && req_hit) begin
                  if (fifo_full) begin
                     overrun <= 1'b1;
                  end else begin
                     fifo_wr    <= 1'b1;
                     fifo_wdata <= word_now;
                  end
               end
            end
            default: ;
         endcase

         case (hs_st)
            HS_IDLE: begin
               if (mode == CAP_HSHAKE && armed && req_hit) begin
                  hold  <= word_now;
                  hs_st <= HS_PEND;
               end
            end
            HS_PEND: begin
               if (!fifo_full) begin
                  fifo_wr    <= 1'b1;
                  fifo_wdata <= hold;
                  ack_start  <= 1'b1;
                  hs_st      <= HS_ACK;
               end
            end
            HS_ACK: begin
               if (!ack_start && !ack_out) hs_st <= HS_IDLE;
            end
            default: hs_st <= HS_IDLE;
         endcase
      end
   end

   incap_ack_gen #(.LEN_W(ACK_LEN_W)) u_ack (
      .clk  (clk),
      .rst_n(rst_n),
      .start(ack_start),
      .len  (cfg_ack_len),
      .ack  (ack_out)
   );

endmodule

// File: rtl/incap_chk.sv
module incap_chk (
   input logic clk,
   input logic rst_n,
   input logic fifo_full,
   input logic fifo_wr,
   input logic ack_out,
   input logic overrun,
   input logic armed
);
   // R2: a write needs the unit to have been armed the cycle before
   p_wr_needs_arm_r2: assert property (@(posedge clk) disable iff (!rst_n)
      fifo_wr |-> $past(armed));

   // R2: arming is never withdrawn
   p_arm_holds_r2: assert property (@(posedge clk) disable iff (!rst_n)
      armed |=> armed);

   // R3: no write is issued against a full FIFO
   p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
      fifo_wr |-> $past(!fifo_full));

   // R6: overrun is sticky
   p_overrun_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
      overrun |=> overrun);

   // R7: acknowledge follows the write by one clock
   p_ack_after_wr_r7: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ack_out) |-> $past(fifo_wr));

   // R9: acknowledge lasts at least two clocks
   p_ack_min_len_r9: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(ack_out) |-> $past(ack_out, 2));

endmodule

bind incap_top incap_chk u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .fifo_full(fifo_full),
   .fifo_wr  (fifo_wr),
   .ack_out  (ack_out),
   .overrun  (overrun),
   .armed    (armed)
);

// File: tb/test_incap_top.sv
module test_incap_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [1:0]  cfg_mode = 2'd3;
   logic        cfg_fall_edge = 1'b0;
   logic [7:0]  cfg_ack_len = 8'd0;
   logic        trig_in = 1'b0;
   logic        pacer_tick = 1'b0;
   logic        req_in = 1'b0;
   logic [31:0] data_in = '0;
   logic        fifo_full = 1'b0;
   logic        fifo_wr;
   logic [31:0] fifo_wdata;
   logic        ack_out;
   logic        overrun;

   int n_vec = 0;
   int n_bad = 0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   incap_top i_incap_top (
      .clk(clk), .rst_n(rst_n), .cfg_mode(cfg_mode), .cfg_fall_edge(cfg_fall_edge),
      .cfg_ack_len(cfg_ack_len), .trig_in(trig_in), .pacer_tick(pacer_tick),
      .req_in(req_in), .data_in(data_in), .fifo_full(fifo_full), .fifo_wr(fifo_wr),
      .fifo_wdata(fifo_wdata), .ack_out(ack_out), .overrun(overrun)
   );

   // {mode[52:51], fall[50], drive_up[49], len[48:41], data[40:9], exp_wr[8], exp_ack[7:0]}
   localparam int NV = 12;
   localparam logic [52:0] VEC [NV] = '{
      {2'd0, 1'b0, 1'b1,  8'd5, 32'h1111_0001, 1'b1,  8'd0},  // R3 pacer, rising req ignored
      {2'd0, 1'b1, 1'b0,  8'd0, 32'hFEDC_BA98, 1'b1,  8'd0},  // R3 pacer, falling req ignored
      {2'd1, 1'b0, 1'b1,  8'd0, 32'hA5A5_5A5A, 1'b1,  8'd0},  // R4 strobe rising
      {2'd1, 1'b0, 1'b0,  8'd0, 32'h0000_0BAD, 1'b0,  8'd0},  // R5 wrong edge
      {2'd1, 1'b1, 1'b0,  8'd0, 32'hCAFE_0001, 1'b1,  8'd0},  // R5 strobe falling
      {2'd1, 1'b1, 1'b1,  8'd0, 32'h0000_0BAD, 1'b0,  8'd0},  // R5 wrong edge
      {2'd2, 1'b0, 1'b1,  8'd0, 32'h1234_5678, 1'b1,  8'd2},  // R9 clamp from 0
      {2'd2, 1'b0, 1'b1,  8'd1, 32'h8765_4321, 1'b1,  8'd2},  // R9 clamp from 1
      {2'd2, 1'b1, 1'b0,  8'd5, 32'hFFFF_FFFF, 1'b1,  8'd5},  // R7 falling handshake
      {2'd2, 1'b0, 1'b1, 8'd17, 32'h0F0F_F0F0, 1'b1, 8'd17},  // R9 long pulse
      {2'd2, 1'b1, 1'b1,  8'd3, 32'h0000_0BAD, 1'b0,  8'd0},  // R5 handshake wrong edge
      {2'd3, 1'b0, 1'b1,  8'd4, 32'h0000_0BAD, 1'b0,  8'd0}   // R10 off
   };

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_vec++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   task automatic cyc(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   task automatic observe(input int n, output int wr_cnt, output logic [31:0] wd,
                          output int wr_at, output int ack_first, output int ack_w);
      wr_cnt = 0; wd = '0; wr_at = -1; ack_first = -1; ack_w = 0;
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         if (i == 0) pacer_tick = 1'b0;
         if (fifo_wr === 1'b1) begin
            wr_cnt++; wd = fifo_wdata;
            if (wr_at < 0) wr_at = i;
         end
         if (ack_out === 1'b1) begin
            ack_w++;
            if (ack_first < 0) ack_first = i;
         end
      end
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_bad++;
         $display("FAIL watchdog: actual hung expected finished");
         $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
         $finish;
      end
   end

   initial begin
      int wc, wa, af, aw;
      logic [31:0] wd;
      logic [52:0] v;

      cyc(3);
      chk("R1 fifo_wr in reset", {31'd0, fifo_wr}, 32'd0);
      chk("R1 ack_out in reset", {31'd0, ack_out}, 32'd0);
      chk("R1 overrun in reset", {31'd0, overrun}, 32'd0);
      rst_n = 1'b1;
      cyc(2);

      // R2: nothing is captured while unarmed
      cfg_mode = 2'd1; data_in = 32'h0BAD_0BAD;
      req_in = 1'b1; observe(8, wc, wd, wa, af, aw);
      chk("R2 strobe before trigger", wc, 0);
      cfg_mode = 2'd0; pacer_tick = 1'b1;
      observe(6, wc, wd, wa, af, aw);
      chk("R2 tick before trigger", wc, 0);
      cfg_mode = 2'd3; req_in = 1'b0;
      trig_in = 1'b1; cyc(2); trig_in = 1'b0; cyc(6);
      cfg_mode = 2'd1; data_in = 32'h5EED_0002; cyc(1);
      req_in = 1'b1; observe(8, wc, wd, wa, af, aw);
      chk("R2 capture after trigger", wc, 1);
      chk("R2 word after trigger", wd, 32'h5EED_0002);

      for (int k = 0; k < NV; k++) begin
         v = VEC[k];
         cfg_mode = 2'd3; cfg_fall_edge = v[50]; cfg_ack_len = v[48:41];
         data_in = v[40:9]; req_in = ~v[49];
         cyc(6);
         cfg_mode = v[52:51];
         cyc(1);
         req_in = v[49]; pacer_tick = 1'b1;
         observe(40, wc, wd, wa, af, aw);
         chk($sformatf("R4 vector %0d write count", k), wc, {31'd0, v[8]});
         if (v[8]) chk($sformatf("R4 vector %0d word", k), wd, v[40:9]);
         chk($sformatf("R9 vector %0d ack width", k), aw, {24'd0, v[7:0]});
         if (v[7:0] != 8'd0) chk($sformatf("R7 vector %0d ack follows write", k), af, wa + 1);
      end

      // R3: pacer tick against a full FIFO is dropped
      cfg_mode = 2'd0; fifo_full = 1'b1; cyc(1);
      pacer_tick = 1'b1; observe(6, wc, wd, wa, af, aw);
      chk("R3 tick while full", wc, 0);
      fifo_full = 1'b0;

      // R6: strobe against a full FIFO flags overrun, which sticks
      cfg_mode = 2'd3; cfg_fall_edge = 1'b0; req_in = 1'b0; cyc(6);
      cfg_mode = 2'd1; fifo_full = 1'b1; cyc(1);
      req_in = 1'b1; observe(8, wc, wd, wa, af, aw);
      chk("R6 strobe while full writes", wc, 0);
      chk("R6 overrun set", {31'd0, overrun}, 32'd1);
      fifo_full = 1'b0; req_in = 1'b0; cyc(6);
      data_in = 32'h0600_0006;
      req_in = 1'b1; observe(8, wc, wd, wa, af, aw);
      chk("R6 later strobe writes", wc, 1);
      chk("R6 overrun stays", {31'd0, overrun}, 32'd1);

      // R8: handshake waits for space
      cfg_mode = 2'd3; req_in = 1'b0; cfg_ack_len = 8'd3; data_in = 32'h0800_0008; cyc(6);
      cfg_mode = 2'd2; fifo_full = 1'b1; cyc(1);
      req_in = 1'b1; observe(12, wc, wd, wa, af, aw);
      chk("R8 no write while full", wc, 0);
      chk("R8 no ack while full", aw, 0);
      fifo_full = 1'b0;
      @(negedge clk);
      chk("R8 write at first free clock", {31'd0, fifo_wr}, 32'd1);
      chk("R8 word", fifo_wdata, 32'h0800_0008);
      @(negedge clk);
      chk("R7 ack one clock after write", {31'd0, ack_out}, 32'd1);
      cyc(10);

      // R1: reset clears the sticky flag
      rst_n = 1'b0; cyc(2);
      chk("R1 overrun cleared", {31'd0, overrun}, 32'd0);
      rst_n = 1'b1; cyc(2);

      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end
endmodule